// File: doc/BRIEF.md
# Vector Arithmetic Exception Recorder

This block sits at the write-back stage of a vector floating-point pipeline. For each element result, the arithmetic units upstream supply a candidate value and four raw condition flags: underflow, divide by zero, reserved operand and overflow. They also supply the element's data format, the instruction's exception-enable bit and the number of the destination vector register. The block picks the word that is written back. That word is the candidate result, a zero, or an encoded reserved operand that carries the exception type in its low bits.

Next to the write-back value, the block keeps a sticky summary for software. The summary holds a 4-bit set of exception types seen and a one-bit-per-register mask of the destinations that took an exception. Both stay set across elements and instructions until a clear pulse arrives. An exception never stalls the element stream, so the remaining elements of the instruction carry on.

Top module: `vexc_recorder`

## Requirements
- R1: The write-back outputs are registered. `wb_valid` is high in the cycle after each cycle with `elem_valid` high, and low otherwise.
- R2: If any condition is effective, `wb_data` is the encoded reserved operand. Bit 15 is one. Bits 3:0 hold the effective conditions (bit 0 underflow, bit 1 divide by zero, bit 2 reserved operand, bit 3 overflow), and several may be set at once. Every other bit is zero, which includes the exponent field (14:7 for F and D, 14:4 for G) and bits 6:4.
- R3: Overflow, divide by zero and reserved operand are effective whatever the value of `exc_en`.
- R4: Underflow is effective only when `exc_en` is 1.
- R5: If underflow is the only flag raised and `exc_en` is 0, `wb_data` is all zero and neither the type register nor the mask changes.
- R6: With no effective condition and no underflow, the candidate is written through. For format code 0 (F), bits 63:32 are forced to zero. For codes 1 (D) and 2 (G), all 64 bits pass unchanged.
- R7: `exc_types` is sticky. Each accepted element ORs its effective conditions into it, using the bit positions of R2.
- R8: An element with any effective condition sets bit `dest_reg` of `dest_mask`. Other bits are kept.
- R9: A `sw_clear` pulse zeroes `exc_types` and `dest_mask` in the next cycle. An exception from an element accepted in the same cycle is still recorded.
- R10: Reset (`rst_n` low) drives `wb_valid`, `wb_data`, `exc_types` and `dest_mask` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| elem_valid | input | 1 | An element result is presented this cycle |
| fmt | input | 2 | Data format: 0 F, 1 D, 2 G |
| exc_en | input | 1 | Exception enable for underflow |
| flag_unf | input | 1 | Raw underflow flag |
| flag_dvz | input | 1 | Raw divide-by-zero flag |
| flag_rsv | input | 1 | Raw reserved-operand flag |
| flag_ovf | input | 1 | Raw overflow flag |
| dest_reg | input | 4 | Destination vector register number |
| cand_result | input | 64 | Candidate result from the arithmetic unit |
| sw_clear | input | 1 | Software clear pulse for the sticky state |
| wb_valid | output | 1 | Write-back word is valid |
| wb_data | output | 64 | Word to write to the destination element |
| exc_types | output | 4 | Sticky set of exception types seen |
| dest_mask | output | 16 | Sticky mask of destination registers that took an exception |

## Verification
The assertions assume that the flags and `dest_reg` are only meaningful while `elem_valid` is high, and that `fmt` never takes code 3. They also assume that `sw_clear` is a pulse that the checks on clearing observe alone, or together with an element. The stimulus keeps to these limits. Flags, enable, format and destination change only while an element is presented, `fmt` sweeps 0 to 2, and clears are issued both alone and together with exception-raising elements. The sweep covers all sixteen flag combinations under both enable values and all three formats, so every suppression and combination case of the encoding is reached.

// File: rtl/vexc_pkg.sv
package vexc_pkg;
   typedef enum logic [1:0] {
      FMT_F = 2'd0,
      FMT_D = 2'd1,
      FMT_G = 2'd2,
      FMT_X = 2'd3
   } fmt_e;

   // condition bit positions inside the type field
   localparam int unsigned COND_UNF = 0;
   localparam int unsigned COND_DVZ = 1;
   localparam int unsigned COND_RSV = 2;
   localparam int unsigned COND_OVF = 3;
   localparam int unsigned COND_W   = 4;

   // reserved operand layout
   localparam int unsigned RSV_SIGN_BIT = 15;
   localparam int unsigned EXP_HI       = 14;
   localparam int unsigned EXP_LO_FD    = 7;
   localparam int unsigned EXP_LO_G     = 4;
endpackage

// File: rtl/vexc_encode.sv
module vexc_encode
   import vexc_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned HALF_W = 32
) (
   input  logic [1:0]        fmt,
   input  logic              exc_en,
   input  logic [COND_W-1:0] raw_cond,
   input  logic [DATA_W-1:0] cand,
   output logic [COND_W-1:0] eff_cond,
   output logic [DATA_W-1:0] result
);
   initial begin
      assert (DATA_W >= RSV_SIGN_BIT + 1) else $error("DATA_W too narrow for encoding");
      assert (HALF_W <= DATA_W) else $error("HALF_W exceeds DATA_W");
   end

   fmt_e              fmt_q;
   logic [DATA_W-1:0] rsv_word;
   logic [DATA_W-1:0] pass_word;
   logic              unf_only;

   assign fmt_q = fmt_e'(fmt);

   always_comb begin
      eff_cond           = raw_cond;
      eff_cond[COND_UNF] = raw_cond[COND_UNF] & exc_en;
   end

   assign unf_only = raw_cond[COND_UNF] & ~exc_en;

   // reserved operand: sign set, exponent cleared per format, type in low bits
   always_comb begin
      rsv_word = '0;
      rsv_word[RSV_SIGN_BIT] = 1'b1;
      if (fmt_q == FMT_G || fmt_q == FMT_X) begin
         rsv_word[EXP_HI:EXP_LO_G] = '0;
      end else begin
         rsv_word[EXP_HI:EXP_LO_FD] = '0;
         rsv_word[EXP_LO_FD-1:COND_W] = '0;
      end
      rsv_word[COND_W-1:0] = eff_cond;
   end

   // pass-through: single-precision format keeps only the low half
   generate
      if (DATA_W > HALF_W) begin : g_split
         always_comb begin
            pass_word = cand;
            if (fmt_q == FMT_F) pass_word[DATA_W-1:HALF_W] = '0;
         end
      end else begin : g_flat
         assign pass_word = cand;
      end
   endgenerate

   always_comb begin
      if (|eff_cond)      result = rsv_word;
      else if (unf_only)  result = '0;
      else                result = pass_word;
   end
endmodule

// File: rtl/vexc_onehot.sv
module vexc_onehot #(
   parameter int unsigned N   = 16,
   parameter int unsigned SEL_W = $clog2(N)
) (
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic [N-1:0]     hot
);
   initial begin
      assert (N >= 2) else $error("decoder needs at least two outputs");
      assert ((1 << SEL_W) >= N) else $error("SEL_W cannot address N");
   end

   generate
      for (genvar i = 0; i < N; i++) begin : g_bit
         assign hot[i] = en && (sel == SEL_W'(i));
      end
   endgenerate
endmodule

// File: rtl/vexc_accum.sv
module vexc_accum #(
   parameter int unsigned TYPE_W = 4,
   parameter int unsigned NREG   = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic [TYPE_W-1:0] type_set,
   input  logic [NREG-1:0]   mask_set,
   output logic [TYPE_W-1:0] type_q,
   output logic [NREG-1:0]   mask_q
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         type_q <= '0;
         mask_q <= '0;
      end else begin
         type_q <= (clr ? '0 : type_q) | type_set;
         mask_q <= (clr ? '0 : mask_q) | mask_set;
      end
   end
endmodule

// File: rtl/vexc_recorder.sv
module vexc_recorder
   import vexc_pkg::*;
#(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned HALF_W = 32,
   parameter int unsigned NREG   = 16,
   localparam int unsigned REG_W = $clog2(NREG)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              elem_valid,
   input  logic [1:0]        fmt,
   input  logic              exc_en,
   input  logic              flag_unf,
   input  logic              flag_dvz,
   input  logic              flag_rsv,
   input  logic              flag_ovf,
   input  logic [REG_W-1:0]  dest_reg,
   input  logic [DATA_W-1:0] cand_result,
   input  logic              sw_clear,
   output logic              wb_valid,
   output logic [DATA_W-1:0] wb_data,
   output logic [COND_W-1:0] exc_types,
   output logic [NREG-1:0]   dest_mask
);
   logic [COND_W-1:0] raw_cond;
   logic [COND_W-1:0] eff_cond;
   logic [COND_W-1:0] type_set;
   logic [DATA_W-1:0] enc_word;
   logic [NREG-1:0]   hot;
   logic              record;

   always_comb begin
      raw_cond           = '0;
      raw_cond[COND_UNF] = flag_unf;
      raw_cond[COND_DVZ] = flag_dvz;
      raw_cond[COND_RSV] = flag_rsv;
      raw_cond[COND_OVF] = flag_ovf;
   end

   vexc_encode #(.DATA_W(DATA_W), .HALF_W(HALF_W)) u_enc (
      .fmt      (fmt),
      .exc_en   (exc_en),
      .raw_cond (raw_cond),
      .cand     (cand_result),
      .eff_cond (eff_cond),
      .result   (enc_word)
   );

   assign record   = elem_valid && (|eff_cond);
   assign type_set = record ? eff_cond : '0;

   vexc_onehot #(.N(NREG), .SEL_W(REG_W)) u_dec (
      .en  (record),
      .sel (dest_reg),
      .hot (hot)
   );

   vexc_accum #(.TYPE_W(COND_W), .NREG(NREG)) u_acc (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (sw_clear),
      .type_set (type_set),
      .mask_set (hot),
      .type_q   (exc_types),
      .mask_q   (dest_mask)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wb_valid <= 1'b0;
         wb_data  <= '0;
      end else begin
         wb_valid <= elem_valid;
         if (elem_valid) wb_data <= enc_word;
      end
   end
endmodule

// File: rtl/vexc_recorder_chk.sv
module vexc_recorder_chk #(
   parameter int unsigned DATA_W = 64,
   parameter int unsigned NREG   = 16,
   localparam int unsigned REG_W = $clog2(NREG)
) (
   input logic              clk,
   input logic              rst_n,
   input logic              elem_valid,
   input logic              exc_en,
   input logic              flag_unf,
   input logic              flag_dvz,
   input logic              flag_rsv,
   input logic              flag_ovf,
   input logic [REG_W-1:0]  dest_reg,
   input logic              sw_clear,
   input logic              wb_valid,
   input logic [DATA_W-1:0] wb_data,
   input logic [3:0]        exc_types,
   input logic [NREG-1:0]   dest_mask
);
   a_r1_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
      elem_valid |=> wb_valid);

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !elem_valid |=> !wb_valid);

   a_r3_always_encoded: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid && (flag_ovf || flag_dvz || flag_rsv))
      |=> (wb_data[15] && wb_data[14:4] == '0));

   a_r5_unf_to_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid && flag_unf && !exc_en && !flag_ovf && !flag_dvz && !flag_rsv)
      |=> (wb_data == '0));

   a_r7_types_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      !sw_clear |=> ((exc_types & $past(exc_types)) == $past(exc_types)));

   a_r8_mask_set: assert property (@(posedge clk) disable iff (!rst_n)
      (elem_valid && flag_ovf) |=> dest_mask[$past(dest_reg)]);

   a_r9_clear_empty: assert property (@(posedge clk) disable iff (!rst_n)
      (sw_clear && !elem_valid) |=> (exc_types == '0 && dest_mask == '0));
endmodule

bind vexc_recorder vexc_recorder_chk #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (.*);

// File: tb/vexc_recorder_test.sv
module vexc_recorder_test;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        elem_valid;
   logic [1:0]  fmt;
   logic        exc_en;
   logic        flag_unf, flag_dvz, flag_rsv, flag_ovf;
   logic [3:0]  dest_reg;
   logic [63:0] cand_result;
   logic        sw_clear;
   logic        wb_valid;
   logic [63:0] wb_data;
   logic [3:0]  exc_types;
   logic [15:0] dest_mask;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [3:0]  m_types;
   logic [15:0] m_mask;

   always #4 clk = ~clk;

   vexc_recorder uut (
      .clk(clk), .rst_n(rst_n), .elem_valid(elem_valid), .fmt(fmt), .exc_en(exc_en),
      .flag_unf(flag_unf), .flag_dvz(flag_dvz), .flag_rsv(flag_rsv), .flag_ovf(flag_ovf),
      .dest_reg(dest_reg), .cand_result(cand_result), .sw_clear(sw_clear),
      .wb_valid(wb_valid), .wb_data(wb_data), .exc_types(exc_types), .dest_mask(dest_mask)
   );

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   // present one element (and optionally a clear), then check on the next negedge
   task automatic apply(input logic [1:0] f, input logic en, input logic [3:0] fl,
                        input logic [3:0] d, input logic [63:0] c, input logic clr);
      logic [3:0]  eff;
      logic [63:0] exp_wb;
      @(negedge clk);
      elem_valid = 1'b1; fmt = f; exc_en = en;
      flag_unf = fl[0]; flag_dvz = fl[1]; flag_rsv = fl[2]; flag_ovf = fl[3];
      dest_reg = d; cand_result = c; sw_clear = clr;
      eff = {fl[3:1], fl[0] & en};
      if (eff != 4'd0)    exp_wb = 64'h8000 | {60'd0, eff};
      else if (fl[0])     exp_wb = 64'd0;
      else if (f == 2'd0) exp_wb = {32'd0, c[31:0]};
      else                exp_wb = c;
      m_types = (clr ? 4'd0 : m_types) | eff;
      m_mask  = (clr ? 16'd0 : m_mask) | ((eff != 4'd0) ? (16'd1 << d) : 16'd0);
      @(negedge clk);
      elem_valid = 1'b0; sw_clear = 1'b0;
      check("R1 wb_valid", {63'd0, wb_valid}, 64'd1);
      if (eff != 4'd0)
         check(fl[3:1] != 3'd0 ? "R2/R3 encoded operand" : "R2/R4 encoded underflow", wb_data, exp_wb);
      else if (fl[0])
         check("R5 suppressed underflow zero", wb_data, exp_wb);
      else
         check("R6 pass-through", wb_data, exp_wb);
      check(clr ? "R9 clear with record types" : "R7 sticky types", {60'd0, exc_types}, {60'd0, m_types});
      check(clr ? "R9 clear with record mask" : "R8 destination mask", {48'd0, dest_mask}, {48'd0, m_mask});
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      int n = 0;
      rst_n = 1'b0; elem_valid = 1'b0; fmt = 2'd0; exc_en = 1'b0;
      flag_unf = 1'b0; flag_dvz = 1'b0; flag_rsv = 1'b0; flag_ovf = 1'b0;
      dest_reg = 4'd0; cand_result = '0; sw_clear = 1'b0;
      m_types = '0; m_mask = '0;
      repeat (3) @(negedge clk);
      check("R10 reset wb_valid", {63'd0, wb_valid}, 64'd0);
      check("R10 reset wb_data", wb_data, 64'd0);
      check("R10 reset types", {60'd0, exc_types}, 64'd0);
      check("R10 reset mask", {48'd0, dest_mask}, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R1 idle wb_valid", {63'd0, wb_valid}, 64'd0);

      for (int f = 0; f < 3; f++) begin
         for (int e = 0; e < 2; e++) begin
            for (int fl = 0; fl < 16; fl++) begin
               logic [63:0] c;
               c = {32'hA5C3_0F00 ^ 32'(n * 977), 32'h1234_5678 + 32'(n * 7919)};
               apply(2'(f), e[0], 4'(fl), 4'((fl + e * 5 + f * 3) % 16), c, (n % 29) == 28);
               n++;
            end
         end
      end

      // suppressed underflow must not disturb the sticky state (R5)
      @(negedge clk); sw_clear = 1'b1;
      m_types = '0; m_mask = '0;
      @(negedge clk); sw_clear = 1'b0;
      check("R9 clear alone types", {60'd0, exc_types}, 64'd0);
      check("R9 clear alone mask", {48'd0, dest_mask}, 64'd0);
      apply(2'd1, 1'b0, 4'b0001, 4'd9, 64'hDEAD_BEEF_0000_1111, 1'b0);
      check("R5 no record types", {60'd0, exc_types}, 64'd0);
      check("R5 no record mask", {48'd0, dest_mask}, 64'd0);

      // every register bit of the mask
      for (int r = 0; r < 16; r++)
         apply(2'd2, 1'b0, 4'b1000, 4'(r), 64'h0, 1'b0);
      check("R8 full mask", {48'd0, dest_mask}, 64'h0000_0000_0000_FFFF);

      @(negedge clk);
      check("R1 idle after burst", {63'd0, wb_valid}, 64'd0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule